// File: doc/BRIEF.md
# ARINC 429 Transmit Descriptor Scheduler

This block sequences the outgoing words of one ARINC 429 transmit channel. Software loads a table of descriptors into a memory. While the run control is high, the scheduler walks that table from entry 0 upward. For each entry it builds one 32-bit word, one byte at a time, and offers that word to a downstream serializer through a valid/accept handshake. Each word byte is taken either from a constant held in the descriptor or from a receive-data memory whose address the descriptor supplies. A byte taken from receive memory can also make the whole word conditional: the word is dropped when that location carries no fresh data.

A pass through the table ends at a marker descriptor, or after the last entry the pointer can reach. What happens next depends on the mode inputs. A repetition timer can hold the next pass back, the next pass can start at once, or the scheduler can stop after a single pass. Lowering the run control parks the scheduler at the next word boundary, and the following run starts again at entry 0.

Top module: `a429_tx_sched`

## Requirements
- R1: While reset is applied and in the first cycle after it, word_valid and rx_clr are low and desc_addr is 0.
- R2: Descriptor n is read at byte address 8·n. Pair i (0..3) occupies desc_data bits [16i+15:16i]. The action code is bits [16i+9:16i+8] and the value byte is bits [16i+7:16i]. Pair i produces word bits [8i+7:8i].
- R3: Action code 00 places the value byte into the word unchanged.
- R4: Action codes 01 and 10 place into the word the receive byte found at rx_addr = value byte. That read pulses rx_clr for the location, which clears its new-data flag. Code 01 uses the byte whatever the flag says.
- R5: Action code 10 with rx_new low drops the word, so it is never offered, and the pointer moves on to the next descriptor.
- R6: Code 11 in pair 0 is the end-of-table marker: the pass ends and the pointer returns to 0. Code 11 in pairs 1 to 3 behaves as code 00.
- R7: With no marker present, the pass ends after entry 2^PTR_W−1 and the pointer wraps to 0.
- R8: Once word_valid rises, the word stays valid and unchanged until word_accept is seen. No byte fetch takes place while a word is offered. Each accept moves the pointer forward by one descriptor.
- R9: Assembly takes four cycles per word. The first word of a run becomes valid after the fifth rising edge that samples run high from idle.
- R10: With immediate low, rep_rate is loaded at each pass start. When a pass is shorter than rep_rate cycles, consecutive passes start exactly rep_rate cycles apart.
- R11: With immediate high, a pass that ended at a marker is followed by the next pass start two cycles after the last accept.
- R12: With single_pass high, exactly one pass is made. No further word appears until run is lowered and raised again.
- R13: Lowering run takes effect at the next word boundary. A word already being assembled or offered is still delivered. The next run starts at descriptor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Run (1) / stop (0) control |
| single_pass | input | 1 | Make one pass, then stop |
| immediate | input | 1 | Start the next pass without waiting for the timer |
| rep_rate | input | REP_W | Pass period in cycles |
| desc_addr | output | PTR_W+3 | Byte address of the current descriptor |
| desc_data | input | 64 | Descriptor read data (combinational) |
| rx_addr | output | 8 | Receive-memory byte address |
| rx_data | input | 8 | Receive-memory read data (combinational) |
| rx_new | input | 1 | New-data flag of the addressed location |
| rx_clr | output | 1 | Clear the new-data flag at rx_addr |
| word_valid | output | 1 | Assembled word offered |
| word_data | output | 32 | Assembled word |
| word_accept | input | 1 | Downstream takes the word |

## Verification
The bench builds the block with PTR_W = 8, so the full 256-entry table is present and the wrap after the last entry can be reached in about 1300 cycles. REP_W is narrowed to 8. That still allows a 40-cycle period, long enough to separate the timer-gated pass start from the two-cycle immediate restart. A behavioural model walks the same table and receive flags to predict every word. Stop, single-pass and conditional-skip cases are also placed where their timing is exact.

// File: rtl/a429_sched_pkg.sv
package a429_sched_pkg;

  typedef enum logic [1:0] {
    ACT_FIXED   = 2'b00,
    ACT_INDEXED = 2'b01,
    ACT_COND    = 2'b10,
    ACT_END     = 2'b11
  } act_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SEND,
    ST_GAP,
    ST_DONE
  } st_e;

  // action code of pair idx inside a 64-bit descriptor
  function automatic act_e act_of(logic [63:0] d, logic [1:0] idx);
    return act_e'(d[{idx, 4'b0000} + 6'd8 +: 2]);
  endfunction

  // value byte of pair idx
  function automatic logic [7:0] val_of(logic [63:0] d, logic [1:0] idx);
    return d[{idx, 4'b0000} +: 8];
  endfunction

endpackage

// File: rtl/a429_byte_src.sv
module a429_byte_src
  import a429_sched_pkg::*;
(
  input  logic [63:0] desc,
  input  logic [1:0]  idx,
  input  logic [7:0]  rx_data,
  input  logic        rx_new,
  output logic [7:0]  rx_addr,
  output logic        rx_rd,
  output logic [7:0]  byte_out,
  output logic        skip_hit,
  output logic        end_hit
);

  act_e       act;
  logic [7:0] val;

  always_comb begin
    act      = act_of(desc, idx);
    val      = val_of(desc, idx);
    end_hit  = (idx == 2'd0) && (act == ACT_END);
    rx_rd    = (act == ACT_INDEXED) || (act == ACT_COND);
    rx_addr  = val;
    byte_out = rx_rd ? rx_data : val;
    skip_hit = (act == ACT_COND) && !rx_new;
  end

endmodule

// File: rtl/a429_rep_timer.sv
module a429_rep_timer #(
  parameter int REP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [REP_W-1:0] load_val,
  output logic             open
);

  logic [REP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign open = (cnt <= REP_W'(1));

  // R10: a freshly loaded non-trivial period keeps the gate shut next cycle
  assert_timer_shut_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear && load_val > REP_W'(2)) |=> !open);

endmodule

// File: rtl/a429_tx_sched.sv
module a429_tx_sched
  import a429_sched_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int REP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               single_pass,
  input  logic               immediate,
  input  logic [REP_W-1:0]   rep_rate,
  output logic [PTR_W+2:0]   desc_addr,
  input  logic [63:0]        desc_data,
  output logic [7:0]         rx_addr,
  input  logic [7:0]         rx_data,
  input  logic               rx_new,
  output logic               rx_clr,
  output logic               word_valid,
  output logic [31:0]        word_data,
  input  logic               word_accept
);

  localparam int DESC_AW = PTR_W + 3;
  localparam logic [PTR_W-1:0] PTR_LAST = '1;

  st_e              st, st_nx;
  logic [PTR_W-1:0] ptr;
  logic [1:0]       bi;
  logic             skip_q;
  logic [31:0]      word_q;

  logic       rx_rd, skip_hit, end_hit, rep_open;
  logic [7:0] byte_out;

  // named internal events
  logic at_boundary, stop_now, end_now, byte_step, last_byte;
  logic skip_now, send_now, word_done, advance, wrap_end, pass_end, pass_start;

  a429_byte_src u_src (
    .desc     (desc_data),
    .idx      (bi),
    .rx_data  (rx_data),
    .rx_new   (rx_new),
    .rx_addr  (rx_addr),
    .rx_rd    (rx_rd),
    .byte_out (byte_out),
    .skip_hit (skip_hit),
    .end_hit  (end_hit)
  );

  a429_rep_timer #(.REP_W(REP_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (stop_now),
    .load     (pass_start),
    .load_val (rep_rate),
    .open     (rep_open)
  );

  always_comb begin
    at_boundary = (st == ST_FETCH) && (bi == 2'd0);
    stop_now    = !run && (at_boundary || st == ST_GAP || st == ST_DONE);
    end_now     = at_boundary && run && end_hit;
    byte_step   = (st == ST_FETCH) && !(at_boundary && (!run || end_hit));
    last_byte   = byte_step && (bi == 2'd3);
    skip_now    = last_byte && (skip_q || skip_hit);
    send_now    = last_byte && !(skip_q || skip_hit);
    word_done   = (st == ST_SEND) && word_accept;
    advance     = skip_now || word_done;
    wrap_end    = advance && (ptr == PTR_LAST);
    pass_end    = end_now || wrap_end;
    pass_start  = run && ((st == ST_IDLE) ||
                          (st == ST_GAP && (immediate || rep_open)));
  end

  always_comb begin
    st_nx = st;
    if (pass_end)             st_nx = single_pass ? ST_DONE : ST_GAP;
    else begin
      unique case (st)
        ST_IDLE:  if (run) st_nx = ST_FETCH;
        ST_FETCH: if (stop_now) st_nx = ST_IDLE;
                  else if (send_now) st_nx = ST_SEND;
        ST_SEND:  if (word_accept) st_nx = ST_FETCH;
        ST_GAP:   if (!run) st_nx = ST_IDLE;
                  else if (pass_start) st_nx = ST_FETCH;
        ST_DONE:  if (!run) st_nx = ST_IDLE;
        default:  st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ptr    <= '0;
      bi     <= 2'd0;
      skip_q <= 1'b0;
      word_q <= '0;
    end else begin
      st <= st_nx;
      if (stop_now || pass_end) ptr <= '0;
      else if (advance)         ptr <= ptr + 1'b1;
      if (byte_step) begin
        bi                     <= bi + 1'b1;
        skip_q                 <= (bi == 2'd3) ? 1'b0 : (skip_q | skip_hit);
        word_q[{bi, 3'b000} +: 8] <= byte_out;
      end
    end
  end

  assign desc_addr  = {ptr, 3'b000};
  assign rx_clr     = byte_step && rx_rd;
  assign word_valid = (st == ST_SEND);
  assign word_data  = word_q;

  // R8: an offered word is held unchanged until taken
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_accept) |=> (word_valid && $stable(word_data)));

  // R8: no receive read while a word is in flight
  assert_no_fetch_in_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !rx_clr);

  // R8: every accept moves to the following descriptor
  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_accept) |=> (desc_addr == $past(desc_addr) + DESC_AW'(8)));

  // R10: every pass begins at descriptor 0 with nothing offered
  assert_pass_from_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pass_start |=> (desc_addr == '0 && !word_valid));

  // R5: a dropped word is never offered
  assert_skip_not_sent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    skip_now |=> !word_valid);

  // R12: after a single pass nothing is offered
  assert_single_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end && single_pass) |=> !word_valid);

endmodule

// File: tb/a429_tx_sched_bench.sv
module a429_tx_sched_bench;
  localparam int PTR_W = 8;
  localparam int REP_W = 8;
  localparam int DEPTH = 1 << PTR_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, run, single_pass, immediate, rx_new, rx_clr, word_valid, word_accept;
  logic [REP_W-1:0] rep_rate;
  logic [PTR_W+2:0] desc_addr;
  logic [63:0] desc_data;
  logic [7:0] rx_addr, rx_data;
  logic [31:0] word_data;

  logic [63:0] desc_mem [DEPTH];
  logic [7:0]  rx_mem [256];
  logic        rx_nf [256];
  logic        mnf [256];

  a429_tx_sched #(.PTR_W(PTR_W), .REP_W(REP_W)) u_a429_tx_sched (
    .clk(clk), .rst_n(rst_n), .run(run), .single_pass(single_pass),
    .immediate(immediate), .rep_rate(rep_rate), .desc_addr(desc_addr),
    .desc_data(desc_data), .rx_addr(rx_addr), .rx_data(rx_data),
    .rx_new(rx_new), .rx_clr(rx_clr), .word_valid(word_valid),
    .word_data(word_data), .word_accept(word_accept));

  assign desc_data = desc_mem[desc_addr[PTR_W+2:3]];
  assign rx_data   = rx_mem[rx_addr];
  assign rx_new    = rx_nf[rx_addr];

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  logic [31:0] expq[$];
  int times[$];
  string cur_req = "R1";
  bit acc_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  bit hold_prev = 1'b0;
  logic [31:0] prev_data = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rx_clr) rx_nf[rx_addr] <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // handshake monitor and accept driver
  always @(negedge clk) begin
    logic [31:0] e;
    word_accept = acc_mode ? lfsr[0] : 1'b1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (hold_prev) chk(word_valid && word_data == prev_data, "R8 hold", word_data, prev_data);
    if (word_valid && word_accept) begin
      if (expq.size() == 0) chk(1'b0, {cur_req, " unexpected word"}, word_data, 32'h0);
      else begin
        e = expq.pop_front();
        chk(word_data == e, cur_req, word_data, e);
      end
      times.push_back(cyc);
    end
    hold_prev = word_valid && !word_accept;
    prev_data = word_data;
  end

  function automatic logic [63:0] mk(input logic [1:0] a0, input logic [7:0] v0,
                                     input logic [1:0] a1, input logic [7:0] v1,
                                     input logic [1:0] a2, input logic [7:0] v2,
                                     input logic [1:0] a3, input logic [7:0] v3);
    return {6'b0, a3, v3, 6'b0, a2, v2, 6'b0, a1, v1, 6'b0, a0, v0};
  endfunction

  // behavioural prediction of one pass
  task automatic model_pass();
    for (int n = 0; n < DEPTH; n++) begin
      logic [63:0] d;
      logic [31:0] w;
      bit skip;
      d = desc_mem[n];
      if (d[9:8] == 2'b11) break;
      skip = 1'b0;
      w = '0;
      for (int i = 0; i < 4; i++) begin
        logic [1:0] a;
        logic [7:0] v;
        a = d[16*i+8 +: 2];
        v = d[16*i +: 8];
        if (a == 2'b01 || a == 2'b10) begin
          if (a == 2'b10 && !mnf[v]) skip = 1'b1;
          w[8*i +: 8] = rx_mem[v];
          mnf[v] = 1'b0;
        end else w[8*i +: 8] = v;
      end
      if (!skip) expq.push_back(w);
    end
  endtask

  task automatic set_flag(input int a, input bit f);
    rx_nf[a] = f;
    mnf[a] = f;
  endtask

  task automatic wait_words(input int n, input int maxc);
    for (int k = 0; k < maxc && times.size() < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected 0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n0, rc;
    logic [31:0] w0;
    for (int i = 0; i < DEPTH; i++) desc_mem[i] = mk(2'b11, 8'h00, 2'b00, 8'h00, 2'b00, 8'h00, 2'b00, 8'h00);
    for (int i = 0; i < 256; i++) begin
      rx_mem[i] = 8'(i) ^ 8'h5A;
      set_flag(i, 1'b0);
    end
    rst_n = 1'b0; run = 1'b0; single_pass = 1'b0; immediate = 1'b0; rep_rate = 8'd40;
    repeat (3) @(negedge clk);
    chk(!word_valid && desc_addr == 0 && !rx_clr, "R1 reset", {word_valid, rx_clr, 19'd0, desc_addr}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!word_valid && desc_addr == 0 && !rx_clr, "R1 after reset", {word_valid, rx_clr, 19'd0, desc_addr}, 32'h0);

    // byte sources, skipping, marker, single pass, back-pressure
    desc_mem[0] = mk(2'b00, 8'h41, 2'b00, 8'h22, 2'b11, 8'h33, 2'b00, 8'h44);
    desc_mem[1] = mk(2'b00, 8'h42, 2'b01, 8'h10, 2'b01, 8'h11, 2'b00, 8'h00);
    desc_mem[2] = mk(2'b00, 8'h43, 2'b10, 8'h20, 2'b00, 8'h99, 2'b10, 8'h21);
    desc_mem[3] = mk(2'b00, 8'h44, 2'b00, 8'h55, 2'b10, 8'h30, 2'b00, 8'h66);
    desc_mem[5] = mk(2'b00, 8'hEE, 2'b00, 8'hEE, 2'b00, 8'hEE, 2'b00, 8'hEE);
    set_flag(16'h20, 1'b1); set_flag(16'h21, 1'b1);
    cur_req = "R2 R3 R4 R5 R6";
    single_pass = 1'b1; acc_mode = 1'b1;
    model_pass();
    chk(expq.size() == 3, "R5 model count", expq.size(), 3);
    n0 = times.size();
    run = 1'b1;
    wait_words(n0 + 3, 400);
    repeat (60) @(negedge clk);
    chk(times.size() == n0 + 3, "R12 one pass", times.size() - n0, 3);
    chk(rx_nf[8'h20] == 1'b0 && rx_nf[8'h21] == 1'b0, "R4 flag cleared", {rx_nf[8'h20], rx_nf[8'h21]}, 0);
    run = 1'b0;
    repeat (5) @(negedge clk);
    cur_req = "R5 R12 second pass";
    model_pass();
    n0 = times.size();
    run = 1'b1;
    wait_words(n0 + 2, 400);
    repeat (60) @(negedge clk);
    chk(times.size() == n0 + 2, "R5 stale word dropped", times.size() - n0, 2);
    run = 1'b0; acc_mode = 1'b0; single_pass = 1'b0;
    repeat (5) @(negedge clk);

    // timer-gated passes, start latency, stop
    desc_mem[0] = mk(2'b00, 8'hA0, 2'b00, 8'hA1, 2'b00, 8'hA2, 2'b00, 8'hA3);
    desc_mem[1] = mk(2'b00, 8'hB0, 2'b00, 8'hB1, 2'b00, 8'hB2, 2'b00, 8'hB3);
    desc_mem[2] = mk(2'b11, 8'h00, 2'b00, 8'h00, 2'b00, 8'h00, 2'b00, 8'h00);
    w0 = 32'hA3A2A1A0;
    expq.delete();
    for (int p = 0; p < 12; p++) model_pass();
    cur_req = "R10 sequence";
    times.delete();
    rc = cyc;
    run = 1'b1;
    wait_words(6, 400);
    chk(times[0] == rc + 5, "R9 first word latency", times[0] - rc, 5);
    chk(times[2] - times[0] == 40, "R10 period", times[2] - times[0], 40);
    chk(times[4] - times[2] == 40, "R10 period again", times[4] - times[2], 40);
    while (!(word_valid && word_data == w0)) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    n0 = times.size();
    repeat (60) @(negedge clk);
    chk(times.size() == n0 && !word_valid, "R13 stop at boundary", times.size() - n0, 0);
    expq.delete();
    for (int p = 0; p < 12; p++) model_pass();
    cur_req = "R13 restart from 0";
    run = 1'b1;
    wait_words(n0 + 1, 100);
    chk(times.size() == n0 + 1, "R13 restart", times.size() - n0, 1);
    while (!(word_valid && word_data == w0)) @(negedge clk);
    n0 = times.size() + 1;
    repeat (2) @(negedge clk);
    run = 1'b0;
    repeat (60) @(negedge clk);
    chk(times.size() == n0 + 1, "R13 word in assembly delivered", times.size() - n0, 1);

    // immediate repeat
    expq.delete();
    for (int p = 0; p < 12; p++) model_pass();
    cur_req = "R11 sequence";
    immediate = 1'b1;
    times.delete();
    run = 1'b1;
    wait_words(6, 400);
    chk(times[2] - times[0] == 12, "R11 immediate period", times[2] - times[0], 12);
    chk(times[4] - times[2] == 12, "R11 immediate period again", times[4] - times[2], 12);
    chk(times[2] - times[1] == 7, "R11 restart after last accept", times[2] - times[1], 7);
    run = 1'b0; immediate = 1'b0;
    repeat (20) @(negedge clk);

    // full table without marker
    for (int i = 0; i < DEPTH; i++)
      desc_mem[i] = mk(2'b00, 8'(i), 2'b00, 8'(i) ^ 8'hFF, 2'b00, 8'h07, 2'b00, 8'h70);
    expq.delete();
    model_pass();
    cur_req = "R7 wrap";
    single_pass = 1'b1;
    n0 = times.size();
    run = 1'b1;
    wait_words(n0 + DEPTH, 2000);
    repeat (50) @(negedge clk);
    chk(times.size() == n0 + DEPTH && expq.size() == 0, "R7 pass ends after last entry", times.size() - n0, DEPTH);
    run = 1'b0;
    repeat (5) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule